// File: doc/BRIEF.md
# Eight-Lane SAD Engine with Running-Minimum Tracker

This block scores candidate blocks for block-matching motion estimation. A candidate is a 16x16 block of 8-bit pixels. It arrives as 32 beats, and each beat carries eight reference pixels and eight candidate pixels. Eight lanes form the absolute differences of one beat in parallel. An accumulator adds the lane totals until the beat flagged as last.

Across a macroblock the block keeps the smallest completed total and the vector tag of the candidate that produced it. A candidate stops accumulating as soon as its partial sum rises above the stored minimum, because it can no longer win. It still consumes its remaining beats, and it is reported as cut short. Two comparators hold the stored minimum against programmable limits. One flag shows a good match below the low limit. The other shows a poor predictor above the high limit, so the search sequencer can widen its grid.

Beats enter on a valid/ready stream. Ready is low during reset and is held high from the first clock after reset, so the block never applies back-pressure. A beat transfers on any cycle where valid and ready are both high, and with valid low the data, first, last and tag pins are ignored. The macroblock clear, the thresholds and the result pins are plain signals.

Top module: `sad_min_engine`

## Requirements
- R1: After the last beat of a candidate that was not cut short, `cand_sad` equals the sum over all of its beats of |ref - cand| for every lane, with pixels unsigned.
- R2: A beat with `in_first` high starts a new total from zero, whatever the previous candidate left behind, including a cut-short state.
- R3: `cand_done` is high in exactly the cycles that follow an accepted beat with `in_last` high.
- R4: On completion, `best_sad` and `best_mv` load the candidate's total and its `in_mv` (sampled on the last beat) only when that total is strictly below the stored minimum.
- R5: When a completed total equals the stored minimum, the earlier candidate's minimum and vector are kept.
- R6: Once a candidate's partial total is greater than the stored minimum, it stops adding. `cand_sad` then freezes at the partial total that first exceeded the minimum, `cand_abort` is high together with `cand_done`, and the stored minimum is unchanged.
- R7: `mb_start` sets `best_sad` to all ones (65535) and `best_mv` to zero. A beat accepted in the same cycle is compared against the all-ones value.
- R8: `thr_below` is high when `best_sad` < `thr_lo`, and `thr_above` is high when `best_sad` > `thr_hi`.
- R9: During reset `best_sad` is 65535, `best_mv` is 0, `cand_done` and `cand_abort` are 0, and `in_ready` is 0.
- R10: With `in_valid` low, the input pins have no effect: no `cand_done`, and no change to the minimum or the vector.
- R11: `in_ready` is high on every cycle after the first clock edge that follows reset release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mb_start | input | 1 | Clears the stored minimum for a new macroblock |
| thr_lo | input | 16 | Low threshold for the good-match flag |
| thr_hi | input | 16 | High threshold for the poor-predictor flag |
| in_valid | input | 1 | Beat valid |
| in_ready | output | 1 | Beat ready |
| in_first | input | 1 | Beat is the first of a candidate |
| in_last | input | 1 | Beat is the last of a candidate |
| in_ref | input | 64 | Eight reference pixels, lane k in bits 8k+7:8k |
| in_cand | input | 64 | Eight candidate pixels, same lane layout |
| in_mv | input | 12 | Candidate vector tag, sampled on the last beat |
| cand_done | output | 1 | One-cycle pulse after a candidate's last beat |
| cand_abort | output | 1 | With cand_done: the candidate was cut short |
| cand_sad | output | 16 | Total (or frozen partial) of the candidate just finished |
| best_sad | output | 16 | Stored minimum SAD |
| best_mv | output | 12 | Vector tag of the stored minimum |
| thr_below | output | 1 | best_sad below thr_lo |
| thr_above | output | 1 | best_sad above thr_hi |

## Verification
The assertions check the timing of the done pulse against accepted last beats and the pairing of abort with done on every cycle. They also check that the minimum never rises except on a clear, that it holds still unless a last beat or a clear arrives, and that ready stays high after reset. Only the bench's scenarios can show the arithmetic: exact totals, the partial value frozen at a cut, which candidate wins a tie, and the threshold flags against chosen limits. The bench compares each candidate's result with a reference model through a scoreboard.

// File: rtl/sad_pkg.sv
package sad_pkg;
  localparam int unsigned DEF_LANES   = 8;
  localparam int unsigned DEF_PIX_W   = 8;
  localparam int unsigned DEF_BLK_PIX = 256;
  localparam int unsigned DEF_MV_W    = 12;

  typedef enum logic {
    CS_RUN = 1'b0,
    CS_CUT = 1'b1
  } cand_state_e;

  function automatic int unsigned sum_width(int unsigned count, int unsigned pix_w);
    return $clog2(count * ((1 << pix_w) - 1) + 1);
  endfunction
endpackage

// File: rtl/sad_lanes.sv
module sad_lanes #(
  parameter int unsigned LANES  = 8,
  parameter int unsigned PIX_W  = 8,
  parameter int unsigned LSUM_W = 11
) (
  input  logic [LANES*PIX_W-1:0] ref_i,
  input  logic [LANES*PIX_W-1:0] cand_i,
  output logic [LSUM_W-1:0]      lsum_o
);
  logic [PIX_W-1:0] ad [LANES];

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [PIX_W-1:0] a, b;
    assign a = ref_i[l*PIX_W +: PIX_W];
    assign b = cand_i[l*PIX_W +: PIX_W];
    assign ad[l] = (a > b) ? (a - b) : (b - a);
  end

  always_comb begin
    lsum_o = '0;
    for (int l = 0; l < LANES; l++) begin
      lsum_o = lsum_o + LSUM_W'(ad[l]);
    end
  end
endmodule

// File: rtl/sad_accum.sv
module sad_accum
  import sad_pkg::*;
#(
  parameter int unsigned SAD_W  = 16,
  parameter int unsigned LSUM_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              beat_i,
  input  logic              first_i,
  input  logic              last_i,
  input  logic [LSUM_W-1:0] lsum_i,
  input  logic [SAD_W-1:0]  min_i,
  output logic [SAD_W-1:0]  sum_o,
  output logic              cut_o,
  output logic [SAD_W-1:0]  acc_o,
  output logic              done_o,
  output logic              abort_o
);
  logic [SAD_W-1:0] acc_q;
  cand_state_e      st_q;
  logic [SAD_W-1:0] base;
  logic             cut_prev;

  always_comb begin
    base     = first_i ? '0 : acc_q;
    cut_prev = first_i ? 1'b0 : (st_q == CS_CUT);
    sum_o    = cut_prev ? base : (base + SAD_W'(lsum_i));
    cut_o    = cut_prev || (sum_o > min_i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc_q   <= '0;
      st_q    <= CS_RUN;
      done_o  <= 1'b0;
      abort_o <= 1'b0;
    end else begin
      done_o  <= beat_i && last_i;
      abort_o <= beat_i && last_i && cut_o;
      if (beat_i) begin
        acc_q <= sum_o;
        st_q  <= cut_o ? CS_CUT : CS_RUN;
      end
    end
  end

  assign acc_o = acc_q;
endmodule

// File: rtl/sad_min_track.sv
module sad_min_track #(
  parameter int unsigned SAD_W = 16,
  parameter int unsigned MV_W  = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             commit_i,
  input  logic [SAD_W-1:0] sad_i,
  input  logic [MV_W-1:0]  mv_i,
  output logic [SAD_W-1:0] min_eff_o,
  output logic [SAD_W-1:0] best_sad_o,
  output logic [MV_W-1:0]  best_mv_o
);
  logic [SAD_W-1:0] best_q;
  logic [MV_W-1:0]  mv_q;

  assign min_eff_o = clear_i ? '1 : best_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q <= '1;
      mv_q   <= '0;
    end else if (commit_i && (sad_i < min_eff_o)) begin
      best_q <= sad_i;
      mv_q   <= mv_i;
    end else if (clear_i) begin
      best_q <= '1;
      mv_q   <= '0;
    end
  end

  assign best_sad_o = best_q;
  assign best_mv_o  = mv_q;
endmodule

// File: rtl/sad_min_engine.sv
module sad_min_engine
  import sad_pkg::*;
#(
  parameter int unsigned LANES   = DEF_LANES,
  parameter int unsigned PIX_W   = DEF_PIX_W,
  parameter int unsigned BLK_PIX = DEF_BLK_PIX,
  parameter int unsigned MV_W    = DEF_MV_W,
  localparam int unsigned SAD_W  = sum_width(BLK_PIX, PIX_W),
  localparam int unsigned LSUM_W = sum_width(LANES, PIX_W)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mb_start,
  input  logic [SAD_W-1:0]       thr_lo,
  input  logic [SAD_W-1:0]       thr_hi,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic                   in_first,
  input  logic                   in_last,
  input  logic [LANES*PIX_W-1:0] in_ref,
  input  logic [LANES*PIX_W-1:0] in_cand,
  input  logic [MV_W-1:0]        in_mv,
  output logic                   cand_done,
  output logic                   cand_abort,
  output logic [SAD_W-1:0]       cand_sad,
  output logic [SAD_W-1:0]       best_sad,
  output logic [MV_W-1:0]        best_mv,
  output logic                   thr_below,
  output logic                   thr_above
);
  logic              ready_q;
  logic              beat;
  logic [LSUM_W-1:0] lsum;
  logic [SAD_W-1:0]  sum_n;
  logic              cut_n;
  logic [SAD_W-1:0]  min_eff;

  always_ff @(posedge clk) begin
    if (!rst_n) ready_q <= 1'b0;
    else        ready_q <= 1'b1;
  end

  assign in_ready = ready_q;
  assign beat     = in_valid && ready_q;

  sad_lanes #(.LANES(LANES), .PIX_W(PIX_W), .LSUM_W(LSUM_W)) lanes_i (
    .ref_i  (in_ref),
    .cand_i (in_cand),
    .lsum_o (lsum)
  );

  sad_accum #(.SAD_W(SAD_W), .LSUM_W(LSUM_W)) accum_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .beat_i  (beat),
    .first_i (in_first),
    .last_i  (in_last),
    .lsum_i  (lsum),
    .min_i   (min_eff),
    .sum_o   (sum_n),
    .cut_o   (cut_n),
    .acc_o   (cand_sad),
    .done_o  (cand_done),
    .abort_o (cand_abort)
  );

  sad_min_track #(.SAD_W(SAD_W), .MV_W(MV_W)) min_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (mb_start),
    .commit_i   (beat && in_last && !cut_n),
    .sad_i      (sum_n),
    .mv_i       (in_mv),
    .min_eff_o  (min_eff),
    .best_sad_o (best_sad),
    .best_mv_o  (best_mv)
  );

  assign thr_below = best_sad < thr_lo;
  assign thr_above = best_sad > thr_hi;
endmodule

// File: rtl/sad_min_engine_chk.sv
module sad_min_engine_chk #(
  parameter int unsigned SAD_W = 16,
  parameter int unsigned MV_W  = 12
) (
  input logic             clk,
  input logic             rst_n,
  input logic             mb_start,
  input logic             in_valid,
  input logic             in_ready,
  input logic             in_last,
  input logic             cand_done,
  input logic             cand_abort,
  input logic [SAD_W-1:0] best_sad,
  input logic [MV_W-1:0]  best_mv
);
  logic last_beat;
  assign last_beat = in_valid && in_ready && in_last;

  // R3
  done_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
    last_beat |=> cand_done);

  // R3
  no_spurious_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !last_beat |=> !cand_done);

  // R6
  abort_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cand_abort |-> cand_done);

  // R4
  min_never_rises_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mb_start |=> (best_sad <= $past(best_sad)));

  // R10
  min_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!mb_start && !last_beat) |=> ($stable(best_sad) && $stable(best_mv)));

  // R7
  clear_min_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mb_start && !last_beat) |=> ((&best_sad) && (best_mv == '0)));

  // R11
  ready_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> in_ready);
endmodule

bind sad_min_engine sad_min_engine_chk #(.SAD_W(SAD_W), .MV_W(MV_W)) chk_i (
  .clk        (clk),
  .rst_n      (rst_n),
  .mb_start   (mb_start),
  .in_valid   (in_valid),
  .in_ready   (in_ready),
  .in_last    (in_last),
  .cand_done  (cand_done),
  .cand_abort (cand_abort),
  .best_sad   (best_sad),
  .best_mv    (best_mv)
);

// File: tb/sad_min_engine_tb_top.sv
module sad_min_engine_tb_top;
  localparam int LANES = 8;
  localparam int PIX_W = 8;
  localparam int BLK   = 256;
  localparam int MV_W  = 12;
  localparam int SAD_W = 16;
  localparam int BEATS = BLK / LANES;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mb_start = 1'b0;
  logic [SAD_W-1:0] thr_lo = '0, thr_hi = '1;
  logic in_valid = 1'b0, in_first = 1'b0, in_last = 1'b0;
  logic [LANES*PIX_W-1:0] in_ref = '0, in_cand = '0;
  logic [MV_W-1:0] in_mv = '0;
  logic in_ready, cand_done, cand_abort, thr_below, thr_above;
  logic [SAD_W-1:0] cand_sad, best_sad;
  logic [MV_W-1:0] best_mv;

  always #2 clk = ~clk;

  sad_min_engine dut_i (
    .clk(clk), .rst_n(rst_n), .mb_start(mb_start), .thr_lo(thr_lo), .thr_hi(thr_hi),
    .in_valid(in_valid), .in_ready(in_ready), .in_first(in_first), .in_last(in_last),
    .in_ref(in_ref), .in_cand(in_cand), .in_mv(in_mv),
    .cand_done(cand_done), .cand_abort(cand_abort), .cand_sad(cand_sad),
    .best_sad(best_sad), .best_mv(best_mv), .thr_below(thr_below), .thr_above(thr_above)
  );

  typedef struct {
    int   sad;
    bit   ab;
    int   bsad;
    int   bmv;
    string req;
  } exp_t;

  exp_t q[$];
  int checks = 0;
  int errors = 0;
  int model_min = 65535;
  int model_mv = 0;
  logic [31:0] lcg = 32'h1234_5678;
  logic [7:0] rpx [BLK];
  logic [7:0] cpx [BLK];

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] rnd();
    lcg = lcg * 32'd1103515245 + 32'd12345;
    return lcg[23:16];
  endfunction

  // mode 0: random pair, 1: cand = ref +/- 0..3, 2: ref 0 cand 255, 3: cand = ref +/- 0..1
  task automatic fill(int mode);
    for (int i = 0; i < BLK; i++) begin
      logic [7:0] r, d;
      r = rnd();
      d = rnd();
      case (mode)
        0: begin rpx[i] = r; cpx[i] = d; end
        1: begin rpx[i] = r; cpx[i] = (r >= 8'd252) ? r - (d & 8'd3) : r + (d & 8'd3); end
        2: begin rpx[i] = 8'd0; cpx[i] = 8'd255; end
        default: begin rpx[i] = r; cpx[i] = (r >= 8'd252) ? r - (d & 8'd1) : r + (d & 8'd1); end
      endcase
    end
  endtask

  task automatic send_cand(int mv, bit gaps, bit clr, string req);
    int acc = 0;
    bit ab = 0;
    int mn;
    exp_t e;
    if (clr) begin model_min = 65535; model_mv = 0; end
    mn = model_min;
    for (int b = 0; b < BEATS; b++) begin
      int ls = 0;
      if (gaps && (b % 5 == 2)) begin
        // R10: junk with valid low, including first/last strobes
        @(negedge clk);
        mb_start = 1'b0;
        in_valid = 1'b0; in_first = 1'b1; in_last = 1'b1;
        in_ref = '1; in_cand = '0; in_mv = '1;
      end
      @(negedge clk);
      in_valid = 1'b1;
      in_first = (b == 0);
      in_last  = (b == BEATS - 1);
      mb_start = clr && (b == 0);
      in_mv    = MV_W'(mv);
      for (int l = 0; l < LANES; l++) begin
        int a, c;
        a = rpx[b*LANES+l];
        c = cpx[b*LANES+l];
        in_ref[l*PIX_W +: PIX_W]  = rpx[b*LANES+l];
        in_cand[l*PIX_W +: PIX_W] = cpx[b*LANES+l];
        ls += (a > c) ? a - c : c - a;
      end
      if (!ab) begin
        acc += ls;
        if (acc > mn) ab = 1;
      end
    end
    if (!ab && acc < mn) begin model_min = acc; model_mv = mv; end
    e.sad = acc; e.ab = ab; e.bsad = model_min; e.bmv = model_mv; e.req = req;
    q.push_back(e);
    @(negedge clk);
    in_valid = 1'b0; in_first = 1'b0; in_last = 1'b0; mb_start = 1'b0;
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cand_done) begin
      if (q.size() == 0) begin
        chk(0, "R3/R10", "unexpected cand_done", 1, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        chk(cand_sad == SAD_W'(e.sad), e.req, "cand_sad", int'(cand_sad), e.sad);
        chk(cand_abort == e.ab, e.req, "cand_abort", int'(cand_abort), int'(e.ab));
        chk(best_sad == SAD_W'(e.bsad), e.req, "best_sad", int'(best_sad), e.bsad);
        chk(best_mv == MV_W'(e.bmv), e.req, "best_mv", int'(best_mv), e.bmv);
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9 reset state
    chk(best_sad == 16'hFFFF, "R9", "best_sad in reset", int'(best_sad), 65535);
    chk(best_mv == 0, "R9", "best_mv in reset", int'(best_mv), 0);
    chk(cand_done == 0 && cand_abort == 0, "R9", "done/abort in reset", int'(cand_done), 0);
    chk(in_ready == 0, "R9", "in_ready in reset", int'(in_ready), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(in_ready == 1, "R11", "in_ready after reset", int'(in_ready), 1);

    // R1 R4 R7: clear plus random candidate
    fill(0); send_cand(1, 0, 1, "R1_R4_R7");
    // R4: closer candidate wins
    fill(1); send_cand(2, 0, 0, "R1_R4");
    // R5: same data, equal total, earlier kept
    send_cand(3, 0, 0, "R5");
    // R6: huge differences cut at first beat
    fill(2); send_cand(4, 0, 0, "R6");
    // R2 R10: fresh total after a cut, with idle junk between beats
    fill(3); send_cand(5, 1, 0, "R2_R10");
    repeat (2) @(negedge clk);

    // R8 thresholds around the current minimum
    thr_lo = SAD_W'(model_min + 1); thr_hi = SAD_W'(model_min - 1);
    @(negedge clk);
    chk(thr_below == 1, "R8", "thr_below above min", int'(thr_below), 1);
    chk(thr_above == 1, "R8", "thr_above below min", int'(thr_above), 1);
    thr_lo = SAD_W'(model_min); thr_hi = SAD_W'(model_min);
    @(negedge clk);
    chk(thr_below == 0, "R8", "thr_below equal", int'(thr_below), 0);
    chk(thr_above == 0, "R8", "thr_above equal", int'(thr_above), 0);

    // R10: lone junk last strobe with valid low, minimum untouched
    in_valid = 1'b0; in_last = 1'b1; in_first = 1'b1; in_ref = '1; in_cand = '0;
    repeat (3) @(negedge clk);
    in_last = 1'b0; in_first = 1'b0;
    chk(best_sad == SAD_W'(model_min), "R10", "best_sad after idle junk", int'(best_sad), model_min);

    // R7: clear coincident with first beat, large total accepted
    fill(0); send_cand(6, 0, 1, "R7");
    // R6: cut midway through against a large minimum
    fill(2); send_cand(7, 0, 0, "R6_mid");
    repeat (4) @(negedge clk);
    chk(q.size() == 0, "R3", "pending results", q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule